// File: doc/BRIEF.md
# NaN Classification and Quieting Unit

This combinational unit examines one IEEE 754 double-precision operand. It reports whether the operand is a NaN and, if so, whether that NaN is signaling. It places the operand in exactly one of six categories on a one-hot output. When the operand is a signaling NaN, the unit also returns the quiet form of that NaN and raises an invalid-operation flag.

A single mode input selects how the top fraction bit, bit 51, is read. With the mode high (the 2008 convention), a set bit 51 marks a quiet NaN. With the mode low (the older convention), a set bit 51 marks a signaling NaN. Quieting under the older convention clears bit 51. If that would leave the fraction all zero, the unit sets bit 50 so that the result is still a NaN.

The unit is meant to sit in front of a floating-point datapath as a small piece of operand-checking logic. It has no clock and no storage.

Top module: `nanq_unit`

## Requirements
- R1: `is_nan_o` is 1 exactly when exponent bits [62:52] are all ones and fraction bits [51:0] are not all zero.
- R2: `is_snan_o` is 1 exactly when `is_nan_o` is 1 and `nan2008_i` XOR bit 51 equals 1. With `nan2008_i`=1 a clear bit 51 marks a signaling NaN; with `nan2008_i`=0 a set bit 51 does.
- R3: For a signaling NaN with `nan2008_i`=1, `quiet_o` equals the operand with bit 51 set.
- R4: For a signaling NaN with `nan2008_i`=0, `quiet_o` equals the operand with bit 51 cleared. If fraction bits [51:0] are then all zero, bit 50 is also set.
- R5: Quieting never alters the sign bit 63 or exponent bits [62:52]. The quieted value is a NaN that the same mode reads as quiet.
- R6: When `is_snan_o` is 0, `quiet_o` equals `op_i`.
- R7: `invalid_o` is 1 exactly when `is_snan_o` is 1.
- R8: `class_o` has exactly one bit set. The bits are: bit 0 zero (exponent 0, fraction 0), bit 1 subnormal (exponent 0, fraction nonzero), bit 2 normal, bit 3 infinity (exponent all ones, fraction 0), bit 4 quiet NaN, bit 5 signaling NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 64 | Double-precision operand |
| nan2008_i | input | 1 | NaN convention: 1 = 2008 style, 0 = older style |
| is_nan_o | output | 1 | Operand is a NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN under the selected convention |
| quiet_o | output | 64 | Quieted operand, or the operand unchanged |
| invalid_o | output | 1 | Invalid-operation flag raised by quieting |
| class_o | output | 6 | One-hot operand category |

## Verification
The sharpest corner case is an older-convention signaling NaN whose only set fraction bit is bit 51. A design without the bit-50 fallback would return an infinity in that case. The bench drives this pattern with both signs.

Infinities are a second corner case. A NaN test that ignores the fraction would flag them as NaNs and quiet them.

Both conventions are driven with the same bit-51 patterns. A design with the XOR polarity inverted would quiet quiet NaNs and pass signaling ones through. Random operands are biased toward an all-ones exponent so that any mismatch in the sign, exponent or untouched fraction bits shows up.

// File: rtl/nanq_pkg.sv
// Shared constants for the NaN classification and quieting unit.
// Assumes the IEEE 754 binary64 layout: sign, then exponent, then fraction.
package nanq_pkg;
    localparam int unsigned DP_EXP_W  = 11;
    localparam int unsigned DP_FRAC_W = 52;

    // Positions of the categories in the one-hot class output
    typedef enum int unsigned {
        CLS_ZERO   = 0,
        CLS_SUB    = 1,
        CLS_NORM   = 2,
        CLS_INF    = 3,
        CLS_QNAN   = 4,
        CLS_SNAN   = 5,
        CLS_COUNT  = 6
    } cls_idx_e;

    localparam int unsigned CLS_W = CLS_COUNT;
endpackage

// File: rtl/nanq_field_decode.sv
// Splits an operand into exponent and fraction summaries.
// Assumes the fraction occupies the low FRAC_W bits and the exponent sits directly above it.
module nanq_field_decode #(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op_i,
    output logic              exp_ones_o,
    output logic              exp_zero_o,
    output logic              frac_zero_o,
    output logic              qbit_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Extract the fields and reduce them to the flags the classifier needs
    always_comb begin
        exp_f       = op_i[WORD_W-2:FRAC_W];
        frac_f      = op_i[FRAC_W-1:0];
        exp_ones_o  = &exp_f;
        exp_zero_o  = ~|exp_f;
        frac_zero_o = ~|frac_f;
        qbit_o      = frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/nanq_classify.sv
// Builds the one-hot category vector from the field flags and the signaling verdict.
// Assumes snan_i is only ever high for operands that are NaNs.
module nanq_classify
    import nanq_pkg::*;
(
    input  logic             exp_ones_i,
    input  logic             exp_zero_i,
    input  logic             frac_zero_i,
    input  logic             snan_i,
    output logic [CLS_W-1:0] class_o
);
    // Set exactly one category bit
    always_comb begin
        class_o = '0;
        if (exp_zero_i) begin
            if (frac_zero_i) class_o[CLS_ZERO] = 1'b1;
            else             class_o[CLS_SUB]  = 1'b1;
        end else if (exp_ones_i) begin
            if (frac_zero_i)  class_o[CLS_INF]  = 1'b1;
            else if (snan_i)  class_o[CLS_SNAN] = 1'b1;
            else              class_o[CLS_QNAN] = 1'b1;
        end else begin
            class_o[CLS_NORM] = 1'b1;
        end
    end
endmodule

// File: rtl/nanq_quieter.sv
// Produces the quiet form of a signaling NaN under either convention.
// Assumes do_quiet_i is high only for signaling NaNs; otherwise the operand passes through.
module nanq_quieter #(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op_i,
    input  logic              nan2008_i,
    input  logic              do_quiet_i,
    output logic [WORD_W-1:0] quiet_o,
    output logic              applied_o
);
    localparam logic [FRAC_W-1:0] QMASK  = {1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FRAC_W-1:0] FBMASK = {2'b01, {(FRAC_W-2){1'b0}}};

    logic [FRAC_W-1:0] frac_in;
    logic [FRAC_W-1:0] frac_set;
    logic [FRAC_W-1:0] frac_clr;
    logic [FRAC_W-1:0] frac_legacy;

    // Form both candidate fractions; the older convention needs the bit-50 fallback
    always_comb begin
        frac_in     = op_i[FRAC_W-1:0];
        frac_set    = frac_in | QMASK;
        frac_clr    = frac_in & ~QMASK;
        frac_legacy = (frac_clr == '0) ? FBMASK : frac_clr;
    end

    // Select the output word and report whether quieting took place
    always_comb begin
        quiet_o   = op_i;
        applied_o = 1'b0;
        if (do_quiet_i) begin
            quiet_o[FRAC_W-1:0] = nan2008_i ? frac_set : frac_legacy;
            applied_o           = 1'b1;
        end
    end
endmodule

// File: rtl/nanq_unit.sv
// Top level: NaN detection, signaling test, quieting and one-hot classification.
// Purely combinational; assumes a binary64-shaped operand given by EXP_W and FRAC_W.
module nanq_unit
    import nanq_pkg::*;
#(
    parameter int unsigned EXP_W  = DP_EXP_W,
    parameter int unsigned FRAC_W = DP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op_i,
    input  logic              nan2008_i,
    output logic              is_nan_o,
    output logic              is_snan_o,
    output logic [WORD_W-1:0] quiet_o,
    output logic              invalid_o,
    output logic [CLS_W-1:0]  class_o
);
    logic exp_ones, exp_zero, frac_zero, qbit;
    logic nan_w, snan_w;

    nanq_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dec_i (
        .op_i        (op_i),
        .exp_ones_o  (exp_ones),
        .exp_zero_o  (exp_zero),
        .frac_zero_o (frac_zero),
        .qbit_o      (qbit)
    );

    // Decide NaN status and signaling status under the selected convention
    always_comb begin
        nan_w  = exp_ones & ~frac_zero;
        snan_w = nan_w & (nan2008_i ^ qbit);
    end

    nanq_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) qt_i (
        .op_i       (op_i),
        .nan2008_i  (nan2008_i),
        .do_quiet_i (snan_w),
        .quiet_o    (quiet_o),
        .applied_o  (invalid_o)
    );

    nanq_classify cls_i (
        .exp_ones_i  (exp_ones),
        .exp_zero_i  (exp_zero),
        .frac_zero_i (frac_zero),
        .snan_i      (snan_w),
        .class_o     (class_o)
    );

    // Drive the status outputs
    always_comb begin
        is_nan_o  = nan_w;
        is_snan_o = snan_w;
    end
endmodule

// File: rtl/nanq_unit_chk.sv
// Checker for nanq_unit: relates the ports of the unit to one another.
// Assumes the unit is combinational, so every check is an immediate assertion on settled values.
module nanq_unit_chk
    import nanq_pkg::*;
#(
    parameter int unsigned EXP_W  = DP_EXP_W,
    parameter int unsigned FRAC_W = DP_FRAC_W,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic [WORD_W-1:0] op_i,
    input logic              nan2008_i,
    input logic              is_nan_o,
    input logic              is_snan_o,
    input logic [WORD_W-1:0] quiet_o,
    input logic              invalid_o,
    input logic [CLS_W-1:0]  class_o
);
    // Check the port relations whenever any of them changes
    always_comb begin
        a_r2_snan_implies_nan: assert (!is_snan_o || is_nan_o)
            else $error("R2: signaling flag without NaN");
        a_r7_invalid_tracks_snan: assert (invalid_o == is_snan_o)
            else $error("R7: invalid flag disagrees with signaling flag");
        a_r6_passthrough: assert (is_snan_o || quiet_o == op_i)
            else $error("R6: output altered for a non-signaling operand");
        a_r5_sign_exp_kept: assert (!is_snan_o || quiet_o[WORD_W-1:FRAC_W] == op_i[WORD_W-1:FRAC_W])
            else $error("R5: sign or exponent altered by quieting");
        a_r5_result_quiet: assert (!is_snan_o ||
                ((quiet_o[FRAC_W-1:0] != '0) && (quiet_o[FRAC_W-1] == nan2008_i)))
            else $error("R5: quieted value is not a quiet NaN");
        a_r8_class_onehot: assert ($onehot(class_o))
            else $error("R8: class vector not one-hot");
        a_r1_nan_class: assert (is_nan_o == (class_o[CLS_QNAN] | class_o[CLS_SNAN]))
            else $error("R1: NaN flag disagrees with class vector");
    end
endmodule

bind nanq_unit nanq_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .op_i      (op_i),
    .nan2008_i (nan2008_i),
    .is_nan_o  (is_nan_o),
    .is_snan_o (is_snan_o),
    .quiet_o   (quiet_o),
    .invalid_o (invalid_o),
    .class_o   (class_o)
);

// File: tb/nanq_unit_tb_top.sv
// Self-checking bench for nanq_unit: directed corner cases plus seeded random operands.
module nanq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op;
    logic        mode;
    logic        is_nan, is_snan, invalid;
    logic [63:0] q;
    logic [5:0]  cls;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    nanq_unit dut_i (
        .op_i      (op),
        .nan2008_i (mode),
        .is_nan_o  (is_nan),
        .is_snan_o (is_snan),
        .quiet_o   (q),
        .invalid_o (invalid),
        .class_o   (cls)
    );

    // Reference model: NaN test
    function automatic bit ref_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
    endfunction

    // Reference model: signaling test
    function automatic bit ref_snan(input logic [63:0] v, input bit m);
        return ref_nan(v) && ((m ^ v[51]) == 1'b1);
    endfunction

    // Reference model: quieted value
    function automatic logic [63:0] ref_quiet(input logic [63:0] v, input bit m);
        logic [63:0] r;
        r = v;
        if (ref_snan(v, m)) begin
            if (m) r[51] = 1'b1;
            else begin
                r[51] = 1'b0;
                if (r[51:0] == 52'd0) r[50] = 1'b1;
            end
        end
        return r;
    endfunction

    // Reference model: one-hot category
    function automatic logic [5:0] ref_class(input logic [63:0] v, input bit m);
        if (v[62:52] == 11'd0)   return (v[51:0] == 52'd0) ? 6'b000001 : 6'b000010;
        if (v[62:52] != 11'h7FF) return 6'b000100;
        if (v[51:0] == 52'd0)    return 6'b001000;
        return ref_snan(v, m) ? 6'b100000 : 6'b010000;
    endfunction

    // Compare one observed value against its expected value
    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h mode=%0d actual=%h expected=%h", req, op, mode, act, exp);
        end
    endtask

    // Drive one operand between edges and check every output after it settles
    task automatic apply(input logic [63:0] v, input bit m);
        logic [63:0] eq;
        @(negedge clk);
        op = v;
        mode = m;
        @(posedge clk);
        #5;
        eq = ref_quiet(v, m);
        cmp("R1", {63'd0, is_nan}, {63'd0, ref_nan(v)});
        cmp("R2", {63'd0, is_snan}, {63'd0, ref_snan(v, m)});
        cmp(ref_snan(v, m) ? (m ? "R3" : "R4") : "R6", q, eq);
        cmp("R5", {52'd0, q[63:52]}, {52'd0, v[63:52]});
        cmp("R7", {63'd0, invalid}, {63'd0, ref_snan(v, m)});
        cmp("R8", {58'd0, cls}, {58'd0, ref_class(v, m)});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // Main stimulus
    initial begin
        logic [63:0] v;
        op = 64'd0;
        mode = 1'b1;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply(64'h0000_0000_0000_0000, 1'b1);                // R8 zero
        apply(64'h8000_0000_0000_0001, 1'b0);                // R8 subnormal
        apply(64'h3FF0_0000_0000_0000, 1'b1);                // R8 normal
        apply(64'h7FF0_0000_0000_0000, 1'b1);                // R1 infinity is not NaN
        apply(64'hFFF0_0000_0000_0000, 1'b0);                // R1 negative infinity
        apply(64'h7FF0_0000_0000_0001, 1'b1);                // R3 signaling under 2008
        apply(64'hFFF0_0000_0000_00FF, 1'b1);                // R3 negative
        apply(64'h7FF8_0000_0000_0000, 1'b1);                // R6 quiet under 2008
        apply(64'h7FF8_0000_0000_0001, 1'b0);                // R4 signaling, older style
        apply(64'h7FF8_0000_0000_0000, 1'b0);                // R4 only bit 51 set: fallback
        apply(64'hFFF8_0000_0000_0000, 1'b0);                // R4 fallback, negative
        apply(64'h7FF0_0000_0000_0001, 1'b0);                // R6 quiet, older style
        apply(64'h7FFC_0000_0000_0000, 1'b0);                // R4 bit 50 already set
        for (int i = 0; i < 3000; i++) begin
            v = {$urandom, $urandom};
            case ($urandom % 4)
                0: ;
                1: v[62:52] = 11'h7FF;
                2: begin v[62:52] = 11'h7FF; v[51:0] = ($urandom % 2) ? 52'h8_0000_0000_0000 : 52'd0; end
                default: v[62:52] = 11'd0;
            endcase
            apply(v, 1'($urandom % 2));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule